// File: doc/BRIEF.md
# Timed Parallel ROM Bank Read Controller

This block sits on the synchronous side of a chip and reads single bytes from a bank of asynchronous parallel read-only memories that share one address bus and one data bus. A requester hands it a combined address. The top bits pick the device, and the remaining bits give the location inside that device. The controller pulls exactly one device-select line low and presents the address. After a lead time it lowers a single output-gate line that all devices share. It captures the data bus once both access paths have certainly settled, then releases both lines and returns the byte.

The memory timing is given in nanoseconds as parameters, together with the clock period. The controller turns these values into whole cycle counts, so one netlist serves fast and slow memory grades. After a device has been released, the controller does not select a different device until that device's output float time has passed. A follow-up read of the same device is not delayed. Request and response each use a valid/ready handshake, and at most one read is in flight.

Top module: `rom_bank_reader`

## Requirements
- R1: After reset every select line and the output gate are high (inactive), `rsp_valid` is low and `req_ready` is high.
- R2: An accepted request drives low only the select line whose index equals `req_addr[DEV_W+ADDR_W-1:ADDR_W]`. At most one select line is low at any time. `mem_addr` carries `req_addr[ADDR_W-1:0]` unchanged from the accept edge until the byte is captured.
- R3: The output gate falls LEAD rising edges after the accept edge, where LEAD = ceil((T_ACC_NS - T_OE_NS) / CLK_NS), clamped at 0. It is low only while a select line is low.
- R4: The data bus is captured at edge SAMP after the accept edge, where SAMP = max(floor(T_ACC_NS/CLK_NS)+1, LEAD+floor(T_OE_NS/CLK_NS)+1). That edge is strictly later than both access deadlines. `rsp_valid` rises with that edge and `rsp_data` equals the addressed device's byte.
- R5: At the capture edge the select line and the output gate both return high.
- R6: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_data` stays unchanged.
- R7: `req_ready` is low from the accept edge until the response has been taken, so only one read is outstanding.
- R8: A request for a device other than the last one released is not accepted before FLT = ceil(T_FLOAT_NS/CLK_NS) edges after the release edge. It is accepted on exactly that edge if it is already waiting. A request for the same device does not wait. Two devices never drive the data bus together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | DEV_W+ADDR_W | Device index (upper bits) and in-device address |
| rsp_valid | output | 1 | Captured byte available |
| rsp_ready | input | 1 | Requester takes the byte |
| rsp_data | output | DATA_W | Captured byte |
| mem_addr | output | ADDR_W | Shared address bus to the devices |
| mem_ce_n | output | 2**DEV_W | Per-device select, active low |
| mem_oe_n | output | 1 | Shared output gate, active low |
| mem_data_in | input | DATA_W | Shared data bus from the devices |

## Verification
With the default timing (4 ns clock, 45/25/25 ns), the output gate is due 5 edges after the accept edge. The response is due 12 edges after it. A switch to another device is due 7 edges after the release edge, and a same-device follow-up is accepted 2 edges after release. A monitor counts rising edges and samples 1 ns before each edge. It records the accept edge from the handshake it sees there and compares each later output event against these edge offsets. A memory model in the bench drives the complement of the true byte until its access deadlines pass, so a capture that comes too early shows up as a data mismatch. The same model keeps each output driving for the float time after release and counts any moment with two drivers.

// File: rtl/rbr_pkg.sv
`timescale 1ns/1ps
package rbr_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_ACTIVE = 2'd1,
        SEQ_RESP   = 2'd2
    } seq_state_e;

    // Smallest cycle count whose duration is at least ns.
    function automatic int ns_to_cyc_ceil(input int ns, input int per);
        return (ns <= 0) ? 0 : (ns + per - 1) / per;
    endfunction

    // First edge strictly later than ns.
    function automatic int ns_to_cyc_after(input int ns, input int per);
        return (ns < 0) ? 0 : (ns / per) + 1;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rbr_ce_decode.sv
`timescale 1ns/1ps
module rbr_ce_decode #(
    parameter int DEV_W   = 2,
    localparam int NUM_DEV = 1 << DEV_W
) (
    input  logic               en_i,
    input  logic [DEV_W-1:0]   dev_i,
    output logic [NUM_DEV-1:0] ce_n_o
);

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_sel
        assign ce_n_o[i] = !(en_i && (dev_i == DEV_W'(i)));
    end

endmodule

// File: rtl/rbr_float_guard.sv
`timescale 1ns/1ps
module rbr_float_guard #(
    parameter int DEV_W   = 2,
    parameter int FLT_CYC = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             release_i,
    input  logic [DEV_W-1:0] rel_dev_i,
    input  logic [DEV_W-1:0] cand_dev_i,
    output logic             clear_o
);

    localparam int FLT_LOAD = (FLT_CYC > 0) ? FLT_CYC - 1 : 0;
    localparam int CW       = $clog2(FLT_LOAD + 2);

    typedef struct packed {
        logic [CW-1:0]    flt;
        logic [DEV_W-1:0] last_dev;
    } guard_reg_t;

    guard_reg_t q, d;

    always_comb begin
        d = q;
        if (release_i) begin
            d.flt      = CW'(FLT_LOAD);
            d.last_dev = rel_dev_i;
        end else if (q.flt != '0) begin
            d.flt = q.flt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign clear_o = (q.flt == '0) || (cand_dev_i == q.last_dev);

endmodule

// File: rtl/rbr_read_seq.sv
`timescale 1ns/1ps
module rbr_read_seq import rbr_pkg::*; #(
    parameter int DEV_W  = 2,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int LEAD   = 5,
    parameter int SAMP   = 12,
    localparam int TOT_W = DEV_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [TOT_W-1:0]  req_addr_i,
    output logic              req_ready_o,
    input  logic              rsp_ready_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_data_o,
    input  logic              clear_i,
    output logic              sample_o,
    output logic              ce_en_o,
    output logic [DEV_W-1:0]  dev_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_oe_n_o,
    input  logic [DATA_W-1:0] mem_data_i
);

    localparam int CNT_W = $clog2(SAMP + 1);
    localparam logic [CNT_W-1:0] OE_AT   = CNT_W'((LEAD > 0) ? LEAD - 1 : 0);
    localparam logic [CNT_W-1:0] SAMP_AT = CNT_W'(SAMP - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DEV_W-1:0]  dev;
        logic              oe_n;
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_data;
    } seq_reg_t;

    seq_reg_t q, d;

    always_comb begin
        d           = q;
        sample_o    = 1'b0;
        req_ready_o = (q.state == SEQ_IDLE) && clear_i;
        unique case (q.state)
            SEQ_IDLE: begin
                if (req_valid_i && req_ready_o) begin
                    d.state = SEQ_ACTIVE;
                    d.cnt   = '0;
                    d.addr  = req_addr_i[ADDR_W-1:0];
                    d.dev   = req_addr_i[TOT_W-1 -: DEV_W];
                    d.oe_n  = (LEAD == 0) ? 1'b0 : 1'b1;
                end
            end
            SEQ_ACTIVE: begin
                d.cnt = q.cnt + 1'b1;
                if ((LEAD > 0) && (q.cnt == OE_AT)) d.oe_n = 1'b0;
                if (q.cnt == SAMP_AT) begin
                    sample_o    = 1'b1;
                    d.oe_n      = 1'b1;
                    d.rsp_valid = 1'b1;
                    d.rsp_data  = mem_data_i;
                    d.state     = SEQ_RESP;
                end
            end
            SEQ_RESP: begin
                if (rsp_ready_i) begin
                    d.rsp_valid = 1'b0;
                    d.state     = SEQ_IDLE;
                end
            end
            default: d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.oe_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ce_en_o     = (q.state == SEQ_ACTIVE);
    assign dev_o       = q.dev;
    assign mem_addr_o  = q.addr;
    assign mem_oe_n_o  = q.oe_n;
    assign rsp_valid_o = q.rsp_valid;
    assign rsp_data_o  = q.rsp_data;

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == SEQ_ACTIVE && $past(q.state) == SEQ_ACTIVE) |-> $stable(q.addr));

    assert_bus_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid_o) |-> (q.oe_n && !ce_en_o));

    assert_resp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o)));

    assert_single_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> !req_ready_o);

endmodule

// File: rtl/rom_bank_reader.sv
`timescale 1ns/1ps
module rom_bank_reader import rbr_pkg::*; #(
    parameter int DEV_W      = 2,
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int CLK_NS     = 4,
    parameter int T_ACC_NS   = 45,
    parameter int T_OE_NS    = 25,
    parameter int T_FLOAT_NS = 25,
    localparam int NUM_DEV   = 1 << DEV_W,
    localparam int TOT_W     = DEV_W + ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [TOT_W-1:0]   req_addr,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [DATA_W-1:0]  rsp_data,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [NUM_DEV-1:0] mem_ce_n,
    output logic               mem_oe_n,
    input  logic [DATA_W-1:0]  mem_data_in
);

    localparam int LEAD = ns_to_cyc_ceil(T_ACC_NS - T_OE_NS, CLK_NS);
    localparam int SAMP = max2(ns_to_cyc_after(T_ACC_NS, CLK_NS),
                               LEAD + ns_to_cyc_after(T_OE_NS, CLK_NS));
    localparam int FLT  = ns_to_cyc_ceil(T_FLOAT_NS, CLK_NS);

    logic             clear;
    logic             sample;
    logic             ce_en;
    logic [DEV_W-1:0] dev;

    rbr_read_seq #(
        .DEV_W (DEV_W),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .LEAD  (LEAD),
        .SAMP  (SAMP)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid_i(req_valid),
        .req_addr_i (req_addr),
        .req_ready_o(req_ready),
        .rsp_ready_i(rsp_ready),
        .rsp_valid_o(rsp_valid),
        .rsp_data_o (rsp_data),
        .clear_i    (clear),
        .sample_o   (sample),
        .ce_en_o    (ce_en),
        .dev_o      (dev),
        .mem_addr_o (mem_addr),
        .mem_oe_n_o (mem_oe_n),
        .mem_data_i (mem_data_in)
    );

    rbr_float_guard #(
        .DEV_W  (DEV_W),
        .FLT_CYC(FLT)
    ) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .release_i (sample),
        .rel_dev_i (dev),
        .cand_dev_i(req_addr[TOT_W-1 -: DEV_W]),
        .clear_o   (clear)
    );

    rbr_ce_decode #(
        .DEV_W(DEV_W)
    ) u_dec (
        .en_i  (ce_en),
        .dev_i (dev),
        .ce_n_o(mem_ce_n)
    );

    assert_one_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_ce_n));

    assert_gate_needs_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !(&mem_ce_n));

endmodule

// File: tb/rom_bank_reader_tb.sv
`timescale 1ns/1ps
module rom_bank_reader_tb;

    localparam int CLK_NS = 4;
    localparam int T_ACC  = 45;
    localparam int T_OE   = 25;
    localparam int T_DF   = 25;
    localparam int LEAD   = (T_ACC - T_OE + CLK_NS - 1) / CLK_NS;
    localparam int SAMP_A = T_ACC / CLK_NS + 1;
    localparam int SAMP_B = LEAD + T_OE / CLK_NS + 1;
    localparam int SAMP   = (SAMP_A > SAMP_B) ? SAMP_A : SAMP_B;
    localparam int FLT    = (T_DF + CLK_NS - 1) / CLK_NS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [17:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [7:0]  rsp_data;
    logic [15:0] mem_addr;
    logic [3:0]  mem_ce_n;
    logic        mem_oe_n;
    logic [7:0]  mem_data_in = 8'hFF;

    always #2 clk = ~clk;

    rom_bank_reader #(
        .DEV_W(2), .ADDR_W(16), .DATA_W(8), .CLK_NS(CLK_NS),
        .T_ACC_NS(T_ACC), .T_OE_NS(T_OE), .T_FLOAT_NS(T_DF)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_data_in(mem_data_in)
    );

    int checks = 0;
    int errors = 0;
    int conflicts = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];

    function automatic logic [7:0] mem_byte(input logic [1:0] dv, input logic [15:0] a);
        return a[7:0] ^ {a[15:10], dv} ^ 8'h3C;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Memory bank model: data is the complement of the stored byte until every
    // access deadline has passed; each output keeps driving for T_DF after release.
    real t_addr = 0.0, t_oe = 0.0;
    real t_ce[4];
    real t_rel[4];
    bit  p_act[4];
    bit  p_cen[4];
    bit  p_oen = 1'b1;
    logic [15:0] p_addr = '0;

    initial begin
        for (int i = 0; i < 4; i++) begin
            t_ce[i] = 0.0; t_rel[i] = -1000.0; p_act[i] = 1'b0; p_cen[i] = 1'b1;
        end
        #0.25;
        forever begin
            real now;
            int nd;
            logic [7:0] bus;
            now = $realtime;
            nd  = 0;
            bus = 8'hFF;
            if (mem_addr != p_addr) t_addr = now;
            p_addr = mem_addr;
            if (!mem_oe_n && p_oen) t_oe = now;
            p_oen = mem_oe_n;
            for (int dv = 0; dv < 4; dv++) begin
                bit act;
                if (!mem_ce_n[dv] && p_cen[dv]) t_ce[dv] = now;
                p_cen[dv] = mem_ce_n[dv];
                act = !mem_ce_n[dv] && !mem_oe_n;
                if (p_act[dv] && !act) t_rel[dv] = now;
                p_act[dv] = act;
                if (act || (now < t_rel[dv] + T_DF)) begin
                    nd++;
                    if (act && now >= t_addr + T_ACC && now >= t_ce[dv] + T_ACC
                        && now >= t_oe + T_OE)
                        bus = mem_byte(2'(dv), mem_addr);
                    else
                        bus = ~mem_byte(2'(dv), mem_addr);
                end
            end
            if (nd > 1) conflicts++;
            mem_data_in = bus;
            #0.5;
        end
    end

    // Monitor: samples 1 ns before each rising edge.
    int ecnt = 0;
    int acc_edge = 0, rel_edge = 0, last_gap = 0;
    bit rel_seen = 1'b0;
    logic [1:0]  acc_dev = '0, rel_dev = '0;
    logic [15:0] acc_addr = '0;
    bit p_oe = 1'b1, p_rsp = 1'b0, hold_pend = 1'b0;
    logic [3:0] p_ce = '0;
    logic [7:0] held = '0;

    always @(posedge clk) ecnt++;

    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            logic [3:0] ce_low;
            ce_low = ~mem_ce_n;
            if (!mem_oe_n && p_oe)
                chk(ecnt - acc_edge == LEAD, "R3 gate fall edge", ecnt - acc_edge, LEAD);
            if (ce_low != 0 && p_ce == 0) begin
                chk(ce_low == (4'b1 << acc_dev), "R2 select line", ce_low, 4'b1 << acc_dev);
                chk(mem_addr == acc_addr, "R2 address", mem_addr, acc_addr);
            end
            if (ce_low == 0 && p_ce != 0) begin
                rel_edge = ecnt; rel_dev = acc_dev; rel_seen = 1'b1;
            end
            if (rsp_valid && !p_rsp) begin
                logic [7:0] e;
                chk(ecnt - acc_edge == SAMP, "R4 capture edge", ecnt - acc_edge, SAMP);
                chk((&mem_ce_n) && mem_oe_n, "R5 release", {mem_ce_n, mem_oe_n}, 5'h1F);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected response", rsp_data, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(rsp_data == e, "R4 data", rsp_data, e);
                end
            end
            if (hold_pend)
                chk(rsp_valid && rsp_data == held, "R6 held response", {rsp_valid, rsp_data}, {1'b1, held});
            hold_pend = rsp_valid && !rsp_ready;
            held      = rsp_data;
            if (rsp_valid && req_valid)
                chk(!req_ready, "R7 ready while pending", req_ready, 0);
            if (req_valid && req_ready) begin
                acc_edge = ecnt + 1;
                acc_dev  = req_addr[17:16];
                acc_addr = req_addr[15:0];
                if (rel_seen) begin
                    last_gap = acc_edge - rel_edge;
                    if (acc_dev != rel_dev)
                        chk(last_gap >= FLT, "R8 float wait", last_gap, FLT);
                end
            end
            p_oe  = mem_oe_n;
            p_ce  = ce_low;
            p_rsp = rsp_valid;
        end
    end

    task automatic send(input logic [1:0] dv, input logic [15:0] a);
        exp_q.push_back(mem_byte(dv, a));
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = {dv, a};
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL R4 watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(&mem_ce_n, "R1 selects idle", mem_ce_n, 4'hF);
        chk(mem_oe_n, "R1 gate idle", mem_oe_n, 1);
        chk(!rsp_valid, "R1 no response", rsp_valid, 0);
        chk(req_ready, "R1 ready", req_ready, 1);

        // R2 R4: single reads across devices and address extremes
        send(2'd0, 16'h0000); wait_idle();
        send(2'd3, 16'hFFFF); wait_idle();
        send(2'd1, 16'h1234); wait_idle();
        send(2'd2, 16'hA5C3); wait_idle();

        // R8: same device back to back needs no float wait
        send(2'd1, 16'h0101);
        send(2'd1, 16'h7E80);
        wait_idle();
        chk(last_gap == 2, "R8 same device gap", last_gap, 2);

        // R8: switch to another device waits exactly the float cycles
        send(2'd2, 16'h3344);
        send(2'd0, 16'hC001);
        wait_idle();
        chk(last_gap == FLT, "R8 switch gap", last_gap, FLT);

        // R6 R7: response back-pressure with a request waiting
        rsp_ready = 1'b0;
        send(2'd3, 16'h00FF);
        fork
            send(2'd0, 16'h0F0F);
        join_none
        while (!rsp_valid) @(negedge clk);
        repeat (6) @(negedge clk);
        rsp_ready = 1'b1;
        wait_idle();

        // mixed burst
        for (int i = 0; i < 24; i++)
            send(2'((i % 4) ^ ((i / 4) % 4)), 16'(i * 16'h0B3D + 7));
        wait_idle();

        chk(conflicts == 0, "R8 bus contention", conflicts, 0);
        chk(exp_q.size() == 0, "R4 responses outstanding", exp_q.size(), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule